// File: doc/BRIEF.md
# Quality-Driven Timing Reference Selector

This block is the decision logic of a network element clock. It watches a set of candidate timing references. Each reference delivers an overhead byte once per frame, and the low four bits of that byte hold a clock-quality code. Each reference also has a signal-fail flag. The block filters each code so that only a value seen on several frames in a row takes effect. It then ranks the references and steers the clock to the best usable one. It also reports the quality of the chosen source downstream.

When nothing usable is left, the block goes into holdover, and the local oscillator carries on alone. Moving to a better source can be delayed by a programmable number of frames, which stops the selection from flapping. When the current source is lost, the block falls back to the next-best source at once. The loop filter, the oscillator and the overhead extraction are outside this block.

Top module: `tref_select`

## Requirements
- R1: After reset, `mode_o` is 00 (free-run), `ql_o` is 1111 and `sel_o` is 0.
- R2: The quality code of a reference is bits [3:0] of its S1 byte; bits [7:4] are ignored. A new code takes effect only after it arrives on 3 consecutive strobes of that reference, and a shorter run changes nothing.
- R3: Code ranks from best to worst are 0001, then 0000, then 1000. Code 1111 and every other code make the reference unusable.
- R4: A reference whose fail flag is high is unusable, whatever its code.
- R5: The best candidate is the usable reference with the highest rank. Among equal ranks, the lower value in its 2-bit `prio_i` field (field i at bits [2i+1:2i]) wins, and after that the lowest index.
- R6: While locked, if the selected reference becomes unusable, selection moves to the best usable reference at the next clock, with no hold-off. If none is usable, the mode becomes holdover (10), and `sel_o` keeps its value.
- R7: While locked to a usable reference, a strictly better candidate is taken only on the `holdoff_i`-th `frame_tick_i` pulse during which it stays strictly better. A `holdoff_i` of 0 switches at the next clock. A candidate that is only equal in rank and priority never displaces the current one.
- R8: `mode_o` is 00 for free-run, 01 for locked and 10 for holdover. Free-run occurs only after reset. `ql_o` equals the accepted code of the selected reference while locked, and 1111 otherwise.
- R9: From free-run or holdover, the block locks to the best candidate at the next clock once any reference is usable, with no hold-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s1_stb_i | input | N_REF | Per-reference strobe: the S1 byte lane is valid |
| s1_byte_i | input | 8*N_REF | S1 bytes, reference i at bits [8i+7:8i] |
| fail_i | input | N_REF | Per-reference signal-fail flag |
| prio_i | input | PRIO_W*N_REF | Per-reference priority; a lower value is preferred |
| holdoff_i | input | HOLD_W | Number of frames to wait before switching to a better source |
| frame_tick_i | input | 1 | One pulse per frame, used for the hold-off count |
| sel_o | output | $clog2(N_REF) | Index of the selected reference |
| mode_o | output | 2 | Operating mode: 00 free-run, 01 locked, 10 holdover |
| ql_o | output | 4 | Quality code passed downstream |

## Verification
The assertions assume the following about the inputs:
- Each strobe is a single-cycle pulse, and its byte lane is valid in that same cycle.
- `prio_i` and `holdoff_i` change only between frames, not while a hold-off count is running.

The bench keeps to this. It pulses strobes for exactly one clock with the byte already in place, and it changes priority or hold-off only while no tick is pending. Fail flags may change in any cycle. The bench uses this to change a flag and a code at the same time, so the fallback and holdover paths see both orders of events.

// File: rtl/tref_pkg.sv
package tref_pkg;
  typedef enum logic [1:0] {
    MODE_FREE = 2'b00,
    MODE_LOCK = 2'b01,
    MODE_HOLD = 2'b10
  } mode_e;

  localparam logic [3:0] QL_DNU = 4'hF;

  // 3 = best, 0 = unusable
  function automatic logic [1:0] ql_rank(input logic [3:0] code);
    case (code)
      4'b0001: ql_rank = 2'd3;
      4'b0000: ql_rank = 2'd2;
      4'b1000: ql_rank = 2'd1;
      default: ql_rank = 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/tref_ssm_filter.sv
module tref_ssm_filter #(
  parameter int CONFIRM = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stb_i,
  input  logic [3:0] nib_i,
  output logic [3:0] code_o
);
  localparam int CNT_W = $clog2(CONFIRM + 1);
  localparam logic [CNT_W-1:0] CONF_L = CNT_W'(CONFIRM);

  logic [3:0]       cand_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;

  assign cnt_nxt = cnt_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_q <= tref_pkg::QL_DNU;
      cnt_q  <= '0;
      code_o <= tref_pkg::QL_DNU;
    end else if (stb_i) begin
      if (nib_i == cand_q) begin
        if (cnt_q != CONF_L) cnt_q <= cnt_nxt;
        if (cnt_nxt >= CONF_L) code_o <= nib_i;
      end else begin
        cand_q <= nib_i;
        cnt_q  <= CNT_W'(1);
        if (CONFIRM <= 1) code_o <= nib_i;
      end
    end
  end

  assert_code_needs_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(code_o) |-> $past(stb_i));
  assert_code_from_input_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(code_o) |-> code_o == $past(nib_i));
endmodule

// File: rtl/tref_rank.sv
module tref_rank #(
  parameter int N_REF   = 4,
  parameter int PRIO_W  = 2,
  parameter int SCORE_W = 2 + PRIO_W,
  parameter int IDX_W   = $clog2(N_REF)
) (
  input  logic [N_REF-1:0][3:0]         code_i,
  input  logic [N_REF-1:0]              fail_i,
  input  logic [N_REF-1:0][PRIO_W-1:0]  prio_i,
  output logic [N_REF-1:0][SCORE_W-1:0] score_o,
  output logic [IDX_W-1:0]              best_idx_o,
  output logic                          best_ok_o
);
  // score 0 = unusable; otherwise {rank, inverted priority}
  for (genvar i = 0; i < N_REF; i++) begin : g_score
    logic [1:0] rnk;
    assign rnk = tref_pkg::ql_rank(code_i[i]);
    assign score_o[i] = (fail_i[i] || rnk == 2'd0) ? '0 : {rnk, ~prio_i[i]};
  end

  logic [SCORE_W-1:0] best_score;

  always_comb begin
    best_idx_o = '0;
    best_score = score_o[0];
    for (int i = 1; i < N_REF; i++) begin
      if (score_o[i] > best_score) begin
        best_score = score_o[i];
        best_idx_o = IDX_W'(i);
      end
    end
    best_ok_o = best_score != '0;
  end
endmodule

// File: rtl/tref_switch_ctrl.sv
module tref_switch_ctrl #(
  parameter int N_REF   = 4,
  parameter int SCORE_W = 4,
  parameter int HOLD_W  = 4,
  parameter int IDX_W   = $clog2(N_REF)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N_REF-1:0][SCORE_W-1:0] score_i,
  input  logic [IDX_W-1:0]              best_idx_i,
  input  logic                          best_ok_i,
  input  logic                          frame_tick_i,
  input  logic [HOLD_W-1:0]             holdoff_i,
  output logic [IDX_W-1:0]              sel_o,
  output tref_pkg::mode_e               mode_o
);
  import tref_pkg::*;

  logic              cur_ok, better;
  logic [HOLD_W-1:0] cnt_q, cnt_nxt;

  assign cur_ok  = score_i[sel_o] != '0;
  assign better  = score_i[best_idx_i] > score_i[sel_o];
  assign cnt_nxt = cnt_q + HOLD_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= MODE_FREE;
      sel_o  <= '0;
      cnt_q  <= '0;
    end else begin
      case (mode_o)
        MODE_LOCK: begin
          if (!cur_ok) begin
            cnt_q <= '0;
            if (best_ok_i) sel_o  <= best_idx_i;
            else           mode_o <= MODE_HOLD;
          end else if (better) begin
            if (holdoff_i == '0) begin
              sel_o <= best_idx_i;
              cnt_q <= '0;
            end else if (frame_tick_i) begin
              if (cnt_nxt >= holdoff_i) begin
                sel_o <= best_idx_i;
                cnt_q <= '0;
              end else begin
                cnt_q <= cnt_nxt;
              end
            end
          end else begin
            cnt_q <= '0;
          end
        end
        default: begin
          cnt_q <= '0;
          if (best_ok_i) begin
            mode_o <= MODE_LOCK;
            sel_o  <= best_idx_i;
          end
        end
      endcase
    end
  end

  assert_holdover_when_none_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_LOCK && !best_ok_i) |=> (mode_o == MODE_HOLD && $stable(sel_o)));
  assert_fallback_at_once_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_LOCK && !cur_ok && best_ok_i) |=>
      (mode_o == MODE_LOCK && sel_o == $past(best_idx_i)));
  assert_no_early_switch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_LOCK && cur_ok && (!better || (holdoff_i != '0 && !frame_tick_i)))
      |=> $stable(sel_o));
  assert_acquire_at_once_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != MODE_LOCK && best_ok_i) |=> (mode_o == MODE_LOCK));
endmodule

// File: rtl/tref_select.sv
module tref_select #(
  parameter int N_REF   = 4,
  parameter int PRIO_W  = 2,
  parameter int HOLD_W  = 4,
  parameter int CONFIRM = 3,
  localparam int IDX_W  = $clog2(N_REF),
  localparam int SCORE_W = 2 + PRIO_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_REF-1:0]         s1_stb_i,
  input  logic [8*N_REF-1:0]       s1_byte_i,
  input  logic [N_REF-1:0]         fail_i,
  input  logic [PRIO_W*N_REF-1:0]  prio_i,
  input  logic [HOLD_W-1:0]        holdoff_i,
  input  logic                     frame_tick_i,
  output logic [IDX_W-1:0]         sel_o,
  output logic [1:0]               mode_o,
  output logic [3:0]               ql_o
);
  import tref_pkg::*;

  logic [N_REF-1:0][3:0]         code;
  logic [N_REF-1:0][PRIO_W-1:0]  prio;
  logic [N_REF-1:0][SCORE_W-1:0] score;
  logic [N_REF-1:0][3:0]         hi_nib;
  logic [IDX_W-1:0]              best_idx;
  logic                          best_ok;
  mode_e                         mode;
  logic                          unused_hi;

  for (genvar i = 0; i < N_REF; i++) begin : g_ref
    assign prio[i]   = prio_i[PRIO_W*i +: PRIO_W];
    assign hi_nib[i] = s1_byte_i[8*i+4 +: 4];
    tref_ssm_filter #(.CONFIRM(CONFIRM)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .stb_i  (s1_stb_i[i]),
      .nib_i  (s1_byte_i[8*i +: 4]),
      .code_o (code[i])
    );
  end

  assign unused_hi = ^hi_nib;

  tref_rank #(.N_REF(N_REF), .PRIO_W(PRIO_W), .SCORE_W(SCORE_W), .IDX_W(IDX_W)) u_rank (
    .code_i     (code),
    .fail_i     (fail_i),
    .prio_i     (prio),
    .score_o    (score),
    .best_idx_o (best_idx),
    .best_ok_o  (best_ok)
  );

  tref_switch_ctrl #(.N_REF(N_REF), .SCORE_W(SCORE_W), .HOLD_W(HOLD_W), .IDX_W(IDX_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .score_i      (score),
    .best_idx_i   (best_idx),
    .best_ok_i    (best_ok),
    .frame_tick_i (frame_tick_i),
    .holdoff_i    (holdoff_i),
    .sel_o        (sel_o),
    .mode_o       (mode)
  );

  assign mode_o = mode;
  assign ql_o   = (mode == MODE_LOCK) ? code[sel_o] : QL_DNU;

  assert_mode_legal_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'b11);
  assert_no_return_to_free_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != 2'b00) |=> (mode_o != 2'b00));
endmodule

// File: tb/tref_select_test.sv
`timescale 1ns/1ps
module tref_select_test;
  localparam int N = 4;
  localparam int PW = 2;
  localparam int HW = 4;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic [N-1:0]    s1_stb = '0;
  logic [8*N-1:0]  s1_byte = '0;
  logic [N-1:0]    fail = '0;
  logic [PW*N-1:0] prio = '0;
  logic [HW-1:0]   holdoff = '0;
  logic            tick = 1'b0;
  logic [1:0]      sel;
  logic [1:0]      mode;
  logic [3:0]      ql;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  tref_select #(.N_REF(N), .PRIO_W(PW), .HOLD_W(HW), .CONFIRM(3)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .s1_stb_i(s1_stb), .s1_byte_i(s1_byte),
    .fail_i(fail), .prio_i(prio), .holdoff_i(holdoff), .frame_tick_i(tick),
    .sel_o(sel), .mode_o(mode), .ql_o(ql)
  );

  // {codes r3..r0, fail, exp sel, exp mode, exp ql}
  localparam logic [27:0] VEC [10] = '{
    {16'hFFFF, 4'b0000, 2'd0, 2'd0, 4'hF},
    {16'hF0F8, 4'b0000, 2'd2, 2'd1, 4'h0},
    {16'hF018, 4'b0000, 2'd1, 2'd1, 4'h1},
    {16'hF018, 4'b0010, 2'd2, 2'd1, 4'h0},
    {16'h1018, 4'b0010, 2'd3, 2'd1, 4'h1},
    {16'hF518, 4'b0000, 2'd1, 2'd1, 4'h1},
    {16'hFFFF, 4'b0000, 2'd1, 2'd2, 4'hF},
    {16'hFFF8, 4'b0000, 2'd0, 2'd1, 4'h8},
    {16'hFF08, 4'b0001, 2'd1, 2'd1, 4'h0},
    {16'hFF08, 4'b1111, 2'd1, 2'd2, 4'hF}
  };

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    s1_stb = '0; fail = '0; tick = 1'b0;
    settle(3);
    rst_ni = 1'b1;
    settle(1);
  endtask

  // one strobe on a single reference, junk in the upper nibble
  task automatic pulse_ref(input int idx, input logic [3:0] code);
    s1_byte[8*idx +: 8] = {4'hA ^ 4'(idx), code};
    s1_stb[idx] = 1'b1;
    @(negedge clk);
    s1_stb = '0;
    @(negedge clk);
  endtask

  task automatic load_ref(input int idx, input logic [3:0] code);
    for (int k = 0; k < 3; k++) pulse_ref(idx, code);
    settle(3);
  endtask

  task automatic load_all(input logic [15:0] codes, input logic [3:0] f);
    fail = f;
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < N; i++) s1_byte[8*i +: 8] = {4'h5 + 4'(k), codes[4*i +: 4]};
      s1_stb = '1;
      @(negedge clk);
      s1_stb = '0;
      @(negedge clk);
    end
    settle(3);
  endtask

  task automatic pulse_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 reset mode", mode, 0);
    chk("R1 reset ql", ql, 4'hF);
    chk("R1 reset sel", sel, 0);

    // table: prio all 0, hold-off 0
    foreach (VEC[v]) begin
      load_all(VEC[v][27:12], VEC[v][11:8]);
      chk($sformatf("R5 R6 vec%0d sel", v), sel, int'(VEC[v][7:6]));
      chk($sformatf("R8 R9 vec%0d mode", v), mode, int'(VEC[v][5:4]));
      chk($sformatf("R3 R4 vec%0d ql", v), ql, int'(VEC[v][3:0]));
    end

    // R2: a run of fewer than 3 equal codes is ignored
    do_reset();
    pulse_ref(0, 4'h1);
    pulse_ref(0, 4'h1);
    settle(3);
    chk("R2 two strobes mode", mode, 0);
    pulse_ref(0, 4'h8);
    pulse_ref(0, 4'h1);
    pulse_ref(0, 4'h1);
    settle(3);
    chk("R2 broken run ql", ql, 4'hF);
    pulse_ref(0, 4'h1);
    settle(3);
    chk("R2 R9 third strobe mode", mode, 1);
    chk("R2 third strobe ql", ql, 4'h1);

    // R5: priority then index tie-break
    do_reset();
    prio = {2'd3, 2'd1, 2'd1, 2'd2};
    load_all(16'h0000, 4'b0000);
    chk("R5 prio tie sel", sel, 1);
    chk("R5 prio tie ql", ql, 4'h0);

    // R7: hold-off of 3 frames
    holdoff = 4'd3;
    load_ref(3, 4'h1);
    chk("R7 no ticks sel", sel, 1);
    pulse_tick();
    pulse_tick();
    chk("R7 two ticks sel", sel, 1);
    pulse_tick();
    settle(1);
    chk("R7 third tick sel", sel, 3);
    chk("R7 third tick ql", ql, 4'h1);

    // R7: equal rank and priority never displaces
    prio = {2'd1, 2'd1, 2'd1, 2'd2};
    load_ref(2, 4'h1);
    for (int k = 0; k < 4; k++) pulse_tick();
    chk("R7 equal score sel", sel, 3);

    // R6: loss of current bypasses hold-off
    fail = 4'b1000;
    settle(2);
    chk("R4 R6 fallback sel", sel, 2);
    chk("R6 fallback mode", mode, 1);

    // R6 holdover then R9 recovery
    fail = 4'b1111;
    settle(2);
    chk("R6 holdover mode", mode, 2);
    chk("R8 holdover ql", ql, 4'hF);
    chk("R6 holdover sel kept", sel, 2);
    fail = 4'b0000;
    settle(2);
    chk("R9 recover mode", mode, 1);
    chk("R9 recover sel", sel, 2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule